// File: doc/BRIEF.md
# Performance Counter Unit

A monitoring block for a processor core. It holds three 32-bit counters. The cycle counter counts every clock. The two event counters each count one strobe chosen from a 64-bit vector of event pulses. All three stop and start together under a single enable bit in the control register. Software sets a sampling period by loading a counter with the two's complement negative of the period. When that counter wraps from all ones to zero, its sticky flag is set. The counter then keeps running.

One control register holds the enable, the per-counter interrupt enables, the sticky flags and the two event-select fields. Writing a 1 to a flag position clears that flag. A handler can therefore write back the control word it just read, and this clears exactly the flags it saw. Two strobe bits in the control word clear the counters. These bits are never stored. The interrupt output is high while any flag is set together with its enable.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, every counter, the enable, the interrupt enables, the flags and both select fields read as zero, and irq_o is low.
- R2: While the enable (control bit 0) is 1, the cycle counter (address 1) increases by one on every clock.
- R3: While enabled, event counter 0 (address 2) increases by one in each cycle where evt_i[sel0] is 1, and event counter 1 (address 3) does the same for evt_i[sel1]. sel0 sits at control bits 17:12 and sel1 at bits 23:18.
- R4: A write to a counter address loads wdata_i on that clock. An increment in the same cycle is discarded.
- R5: When an enabled increment takes a counter from 0xFFFFFFFF to 0, its flag is set. The flags are at control bit 8 (cycle), bit 9 (event 0) and bit 10 (event 1). The counter continues counting from 0.
- R6: A control write clears each flag whose bit position carries a 1 and leaves the others unchanged. Writing back a value just read clears exactly the flags it held.
- R7: If a flag is cleared in the same cycle that its counter overflows, the flag stays set.
- R8: irq_o is high exactly when some flag is set while its interrupt enable is set. The enables are at control bit 4 (cycle), bit 5 (event 0) and bit 6 (event 1).
- R9: Writing 1 to control bit 1 clears both event counters, and writing 1 to bit 2 clears the cycle counter. Both bits always read back as 0.
- R10: While the enable is 0, no counter changes except by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| evt_i | input | 64 | Event pulse vector |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A behavioural model in the bench tracks the unit on every clock, and the bench compares its results with the read data and the interrupt output.

The bench drives several event patterns:
- Only the strobe picked by sel0 pulses.
- Only the strobe picked by sel1 pulses.
- Both pulse together.
- Only unselected strobes pulse.

These patterns show whether each counter is wired to its own select field. Counters preloaded just below the wrap point separate the wrap-to-zero flag from an off-by-one. A flag clear issued in the same cycle as an overflow exposes a write priority given to the wrong side. Runs with the enable off check that the counters hold.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int NUM_CNT  = 3;
  localparam int CNT_W    = 32;
  localparam int EVT_W    = 64;
  localparam int SEL_W    = 6;
  localparam int NUM_EVC  = NUM_CNT - 1;

  // control word layout
  localparam int EN_BIT   = 0;
  localparam int CLRE_BIT = 1;
  localparam int CLRC_BIT = 2;
  localparam int IE_LSB   = 4;
  localparam int FL_LSB   = 8;
  localparam int SEL_LSB  = 12;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CYC  = 2'd1,
    A_EV0  = 2'd2,
    A_EV1  = 2'd3
  } pc_addr_e;
endpackage

// File: rtl/pc_counter.sv
module pc_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         bump;

  // software access beats counting
  assign bump   = inc_i & ~load_i & ~clr_i;
  assign wrap_o = bump & (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (bump)   cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/pc_event_mux.sv
module pc_event_mux #(
  parameter int EVT_W = 64,
  parameter int SEL_W = 6
) (
  input  logic [EVT_W-1:0] evt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < EVT_W; i++)
      if (int'(sel_i) == i) hit_o = evt_i[i];
  end
endmodule

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pc_pkg::*;
#(
  parameter int N   = NUM_CNT,
  parameter int SW  = SEL_W,
  parameter int DW  = CNT_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [N-1:0]          wrap_i,
  output logic                  en_o,
  output logic [N-1:0]          ie_o,
  output logic [N-1:0]          flag_o,
  output logic [N-2:0][SW-1:0]  sel_o,
  output logic                  clr_evt_o,
  output logic                  clr_cyc_o,
  output logic [DW-1:0]         rdata_o
);
  logic                 en_q;
  logic [N-1:0]         ie_q, flag_q, clr_mask;
  logic [N-2:0][SW-1:0] sel_q;

  assign clr_mask  = we_i ? wdata_i[FL_LSB +: N] : '0;
  assign clr_evt_o = we_i & wdata_i[CLRE_BIT];
  assign clr_cyc_o = we_i & wdata_i[CLRC_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ie_q   <= '0;
      sel_q  <= '0;
      flag_q <= '0;
    end else begin
      if (we_i) begin
        en_q  <= wdata_i[EN_BIT];
        ie_q  <= wdata_i[IE_LSB +: N];
        sel_q <= wdata_i[SEL_LSB +: (N-1)*SW];
      end
      // new overflow outranks a clear in the same cycle
      flag_q <= (flag_q & ~clr_mask) | wrap_i;
    end
  end

  always_comb begin
    rdata_o                          = '0;
    rdata_o[EN_BIT]                  = en_q;
    rdata_o[IE_LSB +: N]             = ie_q;
    rdata_o[FL_LSB +: N]             = flag_q;
    rdata_o[SEL_LSB +: (N-1)*SW]     = sel_q;
  end

  assign en_o   = en_q;
  assign ie_o   = ie_q;
  assign flag_o = flag_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [EVT_W-1:0]  evt_i,
  output logic              irq_o
);
  logic                        ctrl_en;
  logic [NUM_CNT-1:0]          ie_q, flag_q, wrap, inc;
  logic [NUM_EVC-1:0][SEL_W-1:0] sel_q;
  logic [NUM_EVC-1:0]          hit;
  logic                        clr_evt, clr_cyc, ctrl_we;
  logic [CNT_W-1:0]            ctrl_rdata;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

  assign ctrl_we = wr_en_i && (addr_i == A_CTRL);

  pc_ctrl #(.N(NUM_CNT), .SW(SEL_W), .DW(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl_we),
    .wdata_i   (wdata_i),
    .wrap_i    (wrap),
    .en_o      (ctrl_en),
    .ie_o      (ie_q),
    .flag_o    (flag_q),
    .sel_o     (sel_q),
    .clr_evt_o (clr_evt),
    .clr_cyc_o (clr_cyc),
    .rdata_o   (ctrl_rdata)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    if (k == 0) begin : g_cyc
      assign inc[k] = ctrl_en;
    end else begin : g_evt
      pc_event_mux #(.EVT_W(EVT_W), .SEL_W(SEL_W)) u_mux (
        .evt_i (evt_i),
        .sel_i (sel_q[k-1]),
        .hit_o (hit[k-1])
      );
      assign inc[k] = ctrl_en & hit[k-1];
    end

    pc_counter #(.W(CNT_W)) u_counter (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (inc[k]),
      .load_i     (wr_en_i && (addr_i == 2'(k + 1))),
      .load_val_i (wdata_i),
      .clr_i      ((k == 0) ? clr_cyc : clr_evt),
      .cnt_o      (cnt_q[k]),
      .wrap_o     (wrap[k])
    );
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_rdata;
      A_CYC:   rdata_o = cnt_q[0];
      A_EV0:   rdata_o = cnt_q[1];
      default: rdata_o = cnt_q[2];
    endcase
  end

  assign irq_o = |(flag_q & ie_q);
endmodule

// File: rtl/pc_checker.sv
module pc_checker
  import pc_pkg::*;
(
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic [1:0]                    addr_i,
  input logic [CNT_W-1:0]              wdata_i,
  input logic                          en_i,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
  input logic [NUM_CNT-1:0]            flags_i,
  input logic                          irq_i
);
  logic cyc_touched;
  assign cyc_touched = wr_en_i && ((addr_i == A_CYC) ||
                       ((addr_i == A_CTRL) && wdata_i[CLRC_BIT]));

  assert_cycle_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !cyc_touched |=> cnt_i[0] == $past(cnt_i[0]) + CNT_W'(1));

  assert_hold_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !wr_en_i |=> $stable(cnt_i));

  assert_write_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == A_CYC |=> cnt_i[0] == $past(wdata_i));

  assert_wrap_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !cyc_touched && (&cnt_i[0]) |=> flags_i[0] && cnt_i[0] == '0);

  assert_irq_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> flags_i != '0);

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_sticky
    assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_i[k] && !(wr_en_i && addr_i == A_CTRL && wdata_i[FL_LSB + k]) |=> flags_i[k]);
  end
endmodule

bind perf_counter_unit pc_checker u_pc_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .en_i    (ctrl_en),
  .cnt_i   (cnt_q),
  .flags_i (flag_q),
  .irq_i   (irq_o)
);

// File: tb/perf_counter_unit_test.sv
module perf_counter_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] evt = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural model state
  logic [31:0] m_cnt [3];
  bit          m_en;
  bit [2:0]    m_ie, m_fl;
  bit [5:0]    m_sel [2];

  always #5 clk = ~clk;

  perf_counter_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  function automatic logic [31:0] m_read(input logic [1:0] a);
    logic [31:0] r = '0;
    if (a == 0) begin
      r[0] = m_en; r[6:4] = m_ie; r[10:8] = m_fl;
      r[17:12] = m_sel[0]; r[23:18] = m_sel[1];
    end else r = m_cnt[a-1];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, compare outputs, advance model
  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d,
                      input logic [63:0] ev, input string tag);
    bit [2:0] inc, ovf, clr;
    logic [31:0] nx [3];
    wr_en = we; addr = a; wdata = d; evt = ev;
    #1;
    chk(tag, rdata, m_read(a));
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, |(m_fl & m_ie)});
    inc[0] = m_en;
    inc[1] = m_en && ev[m_sel[0]];
    inc[2] = m_en && ev[m_sel[1]];
    ovf = '0;
    for (int k = 0; k < 3; k++) begin
      bit cleared = we && a == 0 && ((k == 0) ? d[2] : d[1]);
      bit loaded  = we && a == 2'(k + 1);
      if (cleared)      nx[k] = '0;
      else if (loaded)  nx[k] = d;
      else if (inc[k]) begin
        nx[k] = m_cnt[k] + 1;
        if (m_cnt[k] == 32'hFFFF_FFFF) ovf[k] = 1'b1;
      end else nx[k] = m_cnt[k];
    end
    clr = (we && a == 0) ? d[10:8] : 3'b0;
    @(posedge clk);
    for (int k = 0; k < 3; k++) m_cnt[k] = nx[k];
    m_fl = (m_fl & ~clr) | ovf;
    if (we && a == 0) begin
      m_en = d[0]; m_ie = d[6:4]; m_sel[0] = d[17:12]; m_sel[1] = d[23:18];
    end
    @(negedge clk);
  endtask

  localparam logic [31:0] SELS = (32'd5 << 12) | (32'd9 << 18);

  initial begin
    for (int k = 0; k < 3; k++) m_cnt[k] = '0;
    m_en = 0; m_ie = '0; m_fl = '0; m_sel[0] = '0; m_sel[1] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) step(0, 2'(a), 0, 0, "R1");
    // R2 / R10 start counting
    step(1, 0, 32'h1, 0, "R10");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R2");
    // R3 event selection patterns
    step(1, 0, 32'h1 | SELS, 0, "R3");
    for (int i = 0; i < 3; i++) step(0, 2, 0, 64'h20, "R3");
    for (int i = 0; i < 3; i++) step(0, 3, 0, 64'h200, "R3");
    for (int i = 0; i < 3; i++) step(0, 2, 0, 64'h220, "R3");
    for (int i = 0; i < 3; i++) step(0, 3, 0, 64'hFFFF_FFFF_FFFF_FDDF, "R3");
    step(0, 3, 0, 0, "R3");
    // R10 stopped
    step(1, 0, SELS, 0, "R10");
    for (int i = 0; i < 3; i++) step(0, 2, 0, '1, "R10");
    step(0, 1, 0, 0, "R10");
    // R4 write beats increment, R5 wrap
    step(1, 0, 32'h1 | SELS, 0, "R4");
    step(1, 1, 32'hFFFF_FFFD, 0, "R4");
    step(0, 1, 0, 0, "R4");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R5");
    step(0, 0, 0, 0, "R5");
    // R8 interrupt enables
    step(1, 0, 32'h1 | SELS | 32'h20, 0, "R8");
    step(0, 0, 0, 0, "R8");
    step(1, 0, 32'h1 | SELS | 32'h10, 0, "R8");
    step(0, 0, 0, 0, "R8");
    // R6 write-back clears observed flags
    step(1, 0, 32'h1 | SELS | 32'h10 | 32'h100, 0, "R6");
    step(0, 0, 0, 0, "R6");
    // R7 clear coincides with overflow
    step(1, 1, 32'hFFFF_FFFF, 0, "R7");
    step(1, 0, 32'h1 | SELS | 32'h10 | 32'h100, 0, "R7");
    step(0, 0, 0, 0, "R7");
    // R9 counter clear strobes
    step(1, 2, 32'h1234, 0, "R9");
    step(1, 0, 32'h1 | SELS | 32'h6 | 32'h100, 64'h220, "R9");
    step(0, 0, 0, 0, "R9");
    step(0, 1, 0, 0, "R9");
    step(0, 2, 0, 0, "R9");
    step(0, 3, 0, 0, "R9");
    // event counter wrap raises its flag and interrupt
    step(1, 0, 32'h1 | SELS | 32'h40, 0, "R8");
    step(1, 3, 32'hFFFF_FFFE, 64'h200, "R5");
    step(0, 3, 0, 64'h200, "R5");
    step(0, 3, 0, 64'h200, "R5");
    step(0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, "R8");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule